// File: doc/BRIEF.md
# Periodic comparator timer channel

This block is a single channel of an event timer. It watches a shared free-running main counter, compares it with a programmable comparator and emits a one-cycle fire pulse along with the interrupt route number that pulse should use. Software programs the channel through a small register window. One word holds the mode bits and reports read-only capabilities, and the other holds the comparator.

In one-shot mode the channel fires once when the counter reaches the comparator. In periodic mode, writing the comparator also loads the period, and the comparator then steps forward by one period after each match. A set-value bit lets software move the comparator of a periodic channel without touching its period, and that bit clears itself once used. A narrow mode limits the comparator and the period to 32 bits and compares only the low half of the counter.

When the legacy bit is set, the route fields of channels 0 and 1 are overridden. The instance index is a port, so one design serves every channel of the timer.

Top module: `ptc_channel`

## Requirements
- R1: After reset the configuration word reads 0x00F00000_00000030. The upper half is the allowed-route mask (routes 20..23), bit 4 reports periodic capability and bit 5 reports 64-bit capability. The comparator reads all ones and fire_o is 0.
- R2: Only configuration bits in mask 0x3F4E take writes: bit 1 level, bit 2 enable, bit 3 periodic, bit 6 set-value, bit 8 narrow, bits 13:9 route. All other bits keep their read-only value.
- R3: With global enable and timer enable (bit 2) both 1, the cycle after the counter first equals the comparator, fire_o is 1 for exactly one cycle.
- R4: No pulse is produced while the global enable or the timer enable is 0, even when the counter passes the comparator.
- R5: With bit 3 set and bit 6 clear, a comparator write (offset 0x08) loads both the comparator and the period. The channel then fires at every multiple of the period.
- R6: A period written in periodic mode is raised to at least MIN_PERIOD. Its top bit (bit 31 in narrow mode, bit 63 otherwise) is then cleared. Truncation comes first, then the floor, then the masking.
- R7: With bit 6 set, a comparator write changes only the comparator (no floor), leaves the period alone and clears bit 6.
- R8: With bit 8 set, the comparator and the period are cut to 32 bits, and a one-shot channel matches on the low 32 bits of the counter only.
- R9: route_o equals configuration bits 13:9. When legacy_i is 1, channel index 0 reports route 0 and index 1 reports route 8. Other indices are unaffected.
- R10: On a kick cycle (a register write, or a rise of the global enable), an enabled one-shot channel whose comparator is behind the counter fires at once. In narrow mode this applies only when it is behind by 1..LATE_WIN; a larger lag waits for the low half to wrap.
- R11: An enabled periodic channel whose comparator is below the counter steps the comparator by one period per cycle, without firing, until it is no longer below the counter.
- R12: A one-shot channel does not fire again while the counter stays on the comparator, nor as the counter moves past it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cnt_i | input | 64 | Main counter value |
| glob_en_i | input | 1 | Global enable of the timer |
| legacy_i | input | 1 | Legacy route override |
| tmr_idx_i | input | IDX_W | Index of this channel |
| reg_addr_i | input | 5 | Byte offset in the channel window (0x00 config, 0x08 comparator) |
| reg_wr_i | input | 1 | Write strobe, 64-bit aligned writes |
| reg_wdata_i | input | 64 | Write data |
| reg_rdata_o | output | 64 | Read data for reg_addr_i, zero for other offsets |
| fire_o | output | 1 | One-cycle fire pulse |
| route_o | output | 5 | Interrupt route of the pulse |

## Verification
The bench targets these corner cases:

- Comparator values below the floor, and values with the top bit set, in both widths. A design that masked before truncating, or clamped after masking, would read back the wrong period.
- A set-value write. It must skip the floor and clear bit 6; a design that got this wrong would leave the bit armed or corrupt the period.
- Late one-shot comparators. A 64-bit late comparator must fire once at enable, and a narrow comparator must fire only within the lag window. A design without the window would fire too early, and one without the 64-bit catch would never fire.
- Periodic catch-up with a frozen counter. It must land on the first multiple not below the counter and fire nothing; an off-by-one stops a period early or late.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
   localparam int unsigned REG_W  = 64;
   localparam int unsigned ADDR_W = 5;

   // configuration word bit positions
   localparam int unsigned B_LEVEL    = 1;
   localparam int unsigned B_ENABLE   = 2;
   localparam int unsigned B_PERIODIC = 3;
   localparam int unsigned B_PER_CAP  = 4;
   localparam int unsigned B_WIDE_CAP = 5;
   localparam int unsigned B_SETVAL   = 6;
   localparam int unsigned B_NARROW   = 8;
   localparam int unsigned B_ROUTE_LO = 9;
   localparam int unsigned B_ROUTE_HI = 13;

   localparam logic [REG_W-1:0]  CFG_WR_MASK = 64'h0000_0000_0000_3F4E;
   localparam logic [31:0]       ROUTE_ALLOW = 32'h00F0_0000;
   localparam logic [ADDR_W-1:0] OFS_CFG     = 5'h00;
   localparam logic [ADDR_W-1:0] OFS_CMP     = 5'h08;

   typedef struct packed {
      logic enable;
      logic periodic;
      logic setval;
      logic narrow;
   } ch_mode_t;
endpackage

// File: rtl/ptc_cfg_reg.sv
module ptc_cfg_reg
   import ptc_pkg::*;
#(
   parameter bit          PER_CAP  = 1'b1,
   parameter bit          WIDE_CAP = 1'b1,
   parameter int unsigned IDX_W    = 2,
   parameter int unsigned RT_W     = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [REG_W-1:0] wdata,
   input  logic             setval_clr,
   input  logic             legacy,
   input  logic [IDX_W-1:0] tmr_idx,
   output logic [REG_W-1:0] cfg_rd,
   output ch_mode_t         mode,
   output logic [RT_W-1:0]  route
);
   localparam int unsigned    FIELD_W = B_ROUTE_HI - B_ROUTE_LO + 1;
   localparam logic [RT_W-1:0] LEG_RT0 = RT_W'(0);
   localparam logic [RT_W-1:0] LEG_RT1 = RT_W'(8);

   if (RT_W != FIELD_W) begin : g_bad_rt
      $error("ptc_cfg_reg: RT_W must match the route field width");
   end
   if (IDX_W < 2) begin : g_bad_idx
      $error("ptc_cfg_reg: IDX_W must be at least 2");
   end

   logic [REG_W-1:0] cfg_q;
   logic [REG_W-1:0] cap_bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (cfg_we) begin
         cfg_q <= wdata & CFG_WR_MASK;
      end else if (setval_clr) begin
         cfg_q[B_SETVAL] <= 1'b0;
      end
   end

   always_comb begin
      cap_bits              = '0;
      cap_bits[REG_W-1:32]  = ROUTE_ALLOW;
      cap_bits[B_PER_CAP]   = PER_CAP;
      cap_bits[B_WIDE_CAP]  = WIDE_CAP;
   end

   assign cfg_rd      = cfg_q | cap_bits;
   assign mode.enable = cfg_q[B_ENABLE];
   assign mode.setval = cfg_q[B_SETVAL];

   if (PER_CAP) begin : g_per
      assign mode.periodic = cfg_q[B_PERIODIC];
   end else begin : g_no_per
      assign mode.periodic = 1'b0;
   end

   if (WIDE_CAP) begin : g_wide
      assign mode.narrow = cfg_q[B_NARROW];
   end else begin : g_narrow_only
      assign mode.narrow = 1'b1;
   end

   always_comb begin
      route = cfg_q[B_ROUTE_HI:B_ROUTE_LO];
      if (legacy && tmr_idx == IDX_W'(0)) begin
         route = LEG_RT0;
      end else if (legacy && tmr_idx == IDX_W'(1)) begin
         route = LEG_RT1;
      end
   end

   // R2: read-only capability bits never change
   assert_caps_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd[REG_W-1:32] == ROUTE_ALLOW) && (cfg_rd[B_PER_CAP] == PER_CAP));
endmodule

// File: rtl/ptc_cmp_unit.sv
module ptc_cmp_unit
   import ptc_pkg::*;
#(
   parameter int unsigned NAR_W   = 32,
   parameter int unsigned MIN_PER = 1000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmp_we,
   input  logic             trunc_req,
   input  logic [REG_W-1:0] wdata,
   input  ch_mode_t         mode,
   input  logic             step_ok,
   input  logic [REG_W-1:0] cnt,
   output logic [REG_W-1:0] cmp_q,
   output logic [REG_W-1:0] cmp_vis,
   output logic             setval_clr
);
   localparam logic [REG_W-1:0] NAR_MASK = {{(REG_W-NAR_W){1'b0}}, {NAR_W{1'b1}}};
   localparam logic [REG_W-1:0] FLOOR    = REG_W'(MIN_PER);

   logic [REG_W-1:0] per_q;
   logic [REG_W-1:0] w_trunc;
   logic [REG_W-1:0] w_floor;
   logic [REG_W-1:0] top_keep;
   logic [REG_W-1:0] w_period;
   logic             step_go;

   always_comb begin
      w_trunc  = mode.narrow ? (wdata & NAR_MASK) : wdata;
      w_floor  = (w_trunc < FLOOR) ? FLOOR : w_trunc;
      top_keep = '1;
      if (mode.narrow) top_keep[NAR_W-1] = 1'b0;
      else             top_keep[REG_W-1] = 1'b0;
      w_period = w_floor & top_keep;
   end

   assign step_go = step_ok && mode.periodic && (per_q != '0) && (cnt >= cmp_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q <= '1;
         per_q <= '0;
      end else if (cmp_we) begin
         if (mode.setval) begin
            cmp_q <= w_trunc;
         end else if (mode.periodic) begin
            cmp_q <= w_period;
            per_q <= w_period;
         end else begin
            cmp_q <= w_trunc;
         end
      end else if (trunc_req) begin
         cmp_q <= cmp_q & NAR_MASK;
         per_q <= per_q & NAR_MASK;
      end else if (step_go) begin
         cmp_q <= cmp_q + per_q;
      end
   end

   assign setval_clr = cmp_we && mode.setval;
   assign cmp_vis    = mode.narrow ? (cmp_q & NAR_MASK) : cmp_q;

   // R6: a period loaded by a comparator write never keeps bit 63
   assert_period_top_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_we && !mode.setval && mode.periodic) |=> (per_q[REG_W-1] == 1'b0));

   // R8: entering narrow mode leaves no upper bits in comparator or period
   assert_narrow_trunc_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (trunc_req && !cmp_we) |=> (((cmp_q | per_q) & ~NAR_MASK) == '0));

   // R11: catch-up never moves the comparator backwards
   assert_catchup_forward_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (step_go && !cmp_we && !trunc_req && (cmp_q <= ~per_q)) |=> (cmp_q > $past(cmp_q)));
endmodule

// File: rtl/ptc_fire_unit.sv
module ptc_fire_unit
   import ptc_pkg::*;
#(
   parameter int unsigned NAR_W    = 32,
   parameter int unsigned LATE_WIN = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_all,
   input  logic             kick,
   input  ch_mode_t         mode,
   input  logic [REG_W-1:0] cnt,
   input  logic [REG_W-1:0] cmp,
   output logic             fire_o
);
   logic [NAR_W-1:0] lag_n;
   logic             match_now;
   logic             match_q;
   logic             late;
   logic             fire_d;

   assign lag_n = cnt[NAR_W-1:0] - cmp[NAR_W-1:0];

   always_comb begin
      if (mode.narrow && !mode.periodic) match_now = (cnt[NAR_W-1:0] == cmp[NAR_W-1:0]);
      else                               match_now = (cnt == cmp);
      if (mode.narrow) late = (lag_n != '0) && (lag_n <= NAR_W'(LATE_WIN));
      else             late = (cnt > cmp);
      fire_d = en_all && ((match_now && !match_q) || (kick && !mode.periodic && late));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_q <= 1'b0;
         fire_o  <= 1'b0;
      end else begin
         match_q <= en_all && match_now;
         fire_o  <= fire_d;
      end
   end

   // R3: the pulse is one cycle wide
   assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |=> !fire_o);

   // R4: a pulse is only produced by an enabled channel
   assert_fire_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |-> $past(en_all));
endmodule

// File: rtl/ptc_channel.sv
module ptc_channel
   import ptc_pkg::*;
#(
   parameter int unsigned IDX_W      = 2,
   parameter int unsigned NAR_W      = 32,
   parameter int unsigned MIN_PERIOD = 1000,
   parameter int unsigned LATE_WIN   = 16,
   parameter bit          PER_CAP    = 1'b1,
   parameter bit          WIDE_CAP   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [63:0]       cnt_i,
   input  logic              glob_en_i,
   input  logic              legacy_i,
   input  logic [IDX_W-1:0]  tmr_idx_i,
   input  logic [4:0]        reg_addr_i,
   input  logic              reg_wr_i,
   input  logic [63:0]       reg_wdata_i,
   output logic [63:0]       reg_rdata_o,
   output logic              fire_o,
   output logic [4:0]        route_o
);
   localparam int unsigned RT_W = B_ROUTE_HI - B_ROUTE_LO + 1;

   if (NAR_W < 8 || NAR_W >= REG_W) begin : g_bad_nar
      $error("ptc_channel: NAR_W out of range");
   end
   if (MIN_PERIOD < 2) begin : g_bad_min
      $error("ptc_channel: MIN_PERIOD must be at least 2");
   end
   if (64'(MIN_PERIOD) >= (64'd1 << (NAR_W - 1))) begin : g_bad_floor
      $error("ptc_channel: MIN_PERIOD must fit below the narrow top bit");
   end
   if (64'(LATE_WIN) >= (64'd1 << (NAR_W - 1))) begin : g_bad_win
      $error("ptc_channel: LATE_WIN too large");
   end

   logic             cfg_we;
   logic             cmp_we;
   logic             trunc_req;
   logic             glob_q;
   logic             kick_q;
   logic             en_all;
   logic             setval_clr;
   ch_mode_t         mode;
   logic [REG_W-1:0] cfg_rd;
   logic [REG_W-1:0] cmp_q;
   logic [REG_W-1:0] cmp_vis;
   logic [RT_W-1:0]  route;

   assign cfg_we    = reg_wr_i && (reg_addr_i == OFS_CFG);
   assign cmp_we    = reg_wr_i && (reg_addr_i == OFS_CMP);
   assign trunc_req = cfg_we && reg_wdata_i[B_NARROW];
   assign en_all    = glob_en_i && mode.enable;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glob_q <= 1'b0;
         kick_q <= 1'b0;
      end else begin
         glob_q <= glob_en_i;
         kick_q <= cfg_we || cmp_we || (glob_en_i && !glob_q);
      end
   end

   ptc_cfg_reg #(
      .PER_CAP (PER_CAP),
      .WIDE_CAP(WIDE_CAP),
      .IDX_W   (IDX_W),
      .RT_W    (RT_W)
   ) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .wdata     (reg_wdata_i),
      .setval_clr(setval_clr),
      .legacy    (legacy_i),
      .tmr_idx   (tmr_idx_i),
      .cfg_rd    (cfg_rd),
      .mode      (mode),
      .route     (route)
   );

   ptc_cmp_unit #(
      .NAR_W  (NAR_W),
      .MIN_PER(MIN_PERIOD)
   ) u_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmp_we    (cmp_we),
      .trunc_req (trunc_req),
      .wdata     (reg_wdata_i),
      .mode      (mode),
      .step_ok   (en_all),
      .cnt       (cnt_i),
      .cmp_q     (cmp_q),
      .cmp_vis   (cmp_vis),
      .setval_clr(setval_clr)
   );

   ptc_fire_unit #(
      .NAR_W   (NAR_W),
      .LATE_WIN(LATE_WIN)
   ) u_fire (
      .clk   (clk),
      .rst_n (rst_n),
      .en_all(en_all),
      .kick  (kick_q),
      .mode  (mode),
      .cnt   (cnt_i),
      .cmp   (cmp_q),
      .fire_o(fire_o)
   );

   always_comb begin
      unique case (reg_addr_i)
         OFS_CFG: reg_rdata_o = cfg_rd;
         OFS_CMP: reg_rdata_o = cmp_vis;
         default: reg_rdata_o = '0;
      endcase
   end

   assign route_o = route;

   // R7: the set-value bit is consumed by the comparator write it armed
   assert_setval_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_we && mode.setval) |=> !mode.setval);
endmodule

// File: tb/sim_ptc_channel.sv
module sim_ptc_channel;
   localparam int CLK_PERIOD = 10;
   localparam logic [63:0] CAPS = 64'h00F0_0000_0000_0030;
   localparam logic [4:0]  A_CFG = 5'h00;
   localparam logic [4:0]  A_CMP = 5'h08;

   typedef struct packed {
      logic [63:0] cfg;
      logic [63:0] wv;
      logic [63:0] ecmp;
      logic [63:0] ecfg;
   } vec_t;

   localparam vec_t VECS [0:8] = '{
      '{64'h0,                   64'h0000_0012_3456_789A, 64'h0000_0012_3456_789A, CAPS},          // R3 storage
      '{64'hFFFF_FFFF_FFFF_80B1, 64'h42,                 64'h42,                  CAPS},          // R2 read-only
      '{64'h8,                   64'h5000,               64'h5000,                CAPS | 64'h8},  // R5
      '{64'h8,                   64'h5,                  64'd1000,                CAPS | 64'h8},  // R6 floor
      '{64'h8,                   64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, CAPS | 64'h8}, // R6 top bit
      '{64'h108,                 64'hFFFF_FFFF_8000_0010, 64'h10,                 CAPS | 64'h108},// R6 R8
      '{64'h48,                  64'h7,                  64'h7,                   CAPS | 64'h8},  // R7
      '{64'h100,                 64'hAAAA_BBBB_CCCC_DDDD, 64'hCCCC_DDDD,          CAPS | 64'h100},// R8
      '{64'hFFFF_FFFF_FFFF_FFFF, 64'h3,                  64'h3,                   64'h00F0_0000_0000_3F3E} // R2 R7
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] cnt = '0;
   logic        glob = 1'b0;
   logic        legacy = 1'b0;
   logic [1:0]  idx = 2'd0;
   logic [4:0]  addr = '0;
   logic        wr = 1'b0;
   logic [63:0] wdata = '0;
   logic [63:0] rdata;
   logic        fire;
   logic [4:0]  route;

   int errors = 0;
   int checks = 0;
   int fires = 0;
   int base = 0;
   logic [63:0] v;

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) if (fire) fires <= fires + 1;

   ptc_channel #(
      .IDX_W(2), .NAR_W(32), .MIN_PERIOD(1000), .LATE_WIN(16),
      .PER_CAP(1'b1), .WIDE_CAP(1'b1)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .glob_en_i(glob), .legacy_i(legacy),
      .tmr_idx_i(idx), .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata),
      .reg_rdata_o(rdata), .fire_o(fire), .route_o(route)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wreg(input logic [4:0] a, input logic [63:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic rreg(input logic [4:0] a, output logic [63:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic set_cnt(input logic [63:0] c);
      @(negedge clk);
      cnt = c;
   endtask

   task automatic set_glob(input logic g);
      @(negedge clk);
      glob = g;
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         cnt = cnt + 64'd1;
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rreg(A_CFG, v); check("R1 cfg after reset", v, CAPS);
      rreg(A_CMP, v); check("R1 comparator after reset", v, '1);
      check("R1 fire after reset", 64'(fire), 64'd0);

      // table walk: R2 R5 R6 R7 R8
      for (int k = 0; k < 9; k++) begin
         wreg(A_CFG, VECS[k].cfg);
         wreg(A_CMP, VECS[k].wv);
         rreg(A_CMP, v); check($sformatf("R5/R6/R7/R8 vector %0d comparator", k), v, VECS[k].ecmp);
         rreg(A_CFG, v); check($sformatf("R2/R7 vector %0d config", k), v, VECS[k].ecfg);
      end

      // R3 and R12: one-shot exact timing
      wreg(A_CFG, 64'h0);
      wreg(A_CMP, 64'd100);
      set_cnt(64'd50);
      wreg(A_CFG, 64'h4);
      set_glob(1'b1);
      idle(3);
      base = fires;
      run(49);
      check("R3 no early fire", 64'(fires - base), 64'd0);
      @(negedge clk); cnt = 64'd100;
      @(negedge clk); check("R3 pulse one cycle after match", 64'(fire), 64'd1);
      @(negedge clk); check("R12 held counter no refire", 64'(fire), 64'd0);
      run(200);
      idle(3);
      check("R12 single one-shot pulse", 64'(fires - base), 64'd1);
      set_glob(1'b0);

      // R4 disabled paths
      wreg(A_CFG, 64'h4);
      wreg(A_CMP, 64'd300);
      set_cnt(64'd250);
      base = fires;
      run(100);
      idle(3);
      check("R4 global enable off", 64'(fires - base), 64'd0);
      wreg(A_CFG, 64'h0);
      set_glob(1'b1);
      set_cnt(64'd250);
      run(100);
      idle(3);
      check("R4 timer enable off", 64'(fires - base), 64'd0);
      set_glob(1'b0);

      // R5 periodic firing
      set_cnt(64'd0);
      wreg(A_CFG, 64'hC);
      wreg(A_CMP, 64'd1000);
      base = fires;
      set_glob(1'b1);
      run(3500);
      idle(3);
      check("R5 periodic pulse count", 64'(fires - base), 64'd3);
      rreg(A_CMP, v); check("R5 comparator advanced", v, 64'd4000);
      set_glob(1'b0);

      // R11 catch-up with frozen counter
      set_cnt(64'd5500);
      wreg(A_CMP, 64'd1000);
      base = fires;
      set_glob(1'b1);
      idle(20);
      set_glob(1'b0);
      idle(2);
      check("R11 catch-up silent", 64'(fires - base), 64'd0);
      rreg(A_CMP, v); check("R11 catch-up target", v, 64'd6000);

      // R10 late one-shot, 64-bit
      wreg(A_CFG, 64'h4);
      wreg(A_CMP, 64'd200);
      set_cnt(64'd100000);
      base = fires;
      set_glob(1'b1);
      idle(10);
      check("R10 wide late fires once", 64'(fires - base), 64'd1);
      set_glob(1'b0);

      // R10 late one-shot, narrow within window
      wreg(A_CFG, 64'h104);
      wreg(A_CMP, 64'h1000);
      set_cnt(64'h1005);
      base = fires;
      set_glob(1'b1);
      idle(10);
      check("R10 narrow small lag fires", 64'(fires - base), 64'd1);
      set_glob(1'b0);

      // R10 narrow far lag waits
      set_cnt(64'h2000);
      base = fires;
      set_glob(1'b1);
      idle(10);
      check("R10 narrow far lag waits", 64'(fires - base), 64'd0);

      // R8 low-half match with upper counter bits set
      set_cnt(64'h1_0000_0FFE);
      run(5);
      idle(3);
      check("R8 low 32-bit match", 64'(fires - base), 64'd1);
      set_glob(1'b0);

      // R9 routing
      wreg(A_CFG, 64'h2A00);
      @(negedge clk); idx = 2'd0; legacy = 1'b0;
      #1 check("R9 route field", 64'(route), 64'd21);
      @(negedge clk); legacy = 1'b1;
      #1 check("R9 legacy index 0", 64'(route), 64'd0);
      @(negedge clk); idx = 2'd1;
      #1 check("R9 legacy index 1", 64'(route), 64'd8);
      @(negedge clk); idx = 2'd2;
      #1 check("R9 legacy index 2 unaffected", 64'(route), 64'd21);
      @(negedge clk); legacy = 1'b0;

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule